// File: doc/BRIEF.md
# Video Raster Flywheel

This block follows the raster of a parallel digital video stream. It takes one 10-bit word per enabled clock and finds where lines and frames begin. The timing can come from external horizontal, vertical and field pins. It can also come from the timing-reference words carried in the data. From that timing the block measures four values: words per line, active words per line, lines per frame and active lines per frame.

A candidate geometry is accepted when two consecutive complete frames measure the same. The block then raises its lock flag and drives regenerated horizontal, vertical and field outputs from free-running counters. While locked it keeps comparing every new measurement with the stored geometry. A run of consecutive disagreements drops the lock and starts learning again. The block works only while its mode inputs select the scrambled-video operating mode. In any other mode it is held cleared.

Top module: `vid_flywheel`

## Requirements
- R1: The block runs only while `mode_bypass`=1 and `mode_asi`=0. In any other mode, `locked`, `h_out`, `v_out` and `f_out` read 0 at once. From the next clock edge all learned values read 0, and lock must be earned again from scratch.
- R2: With `src_trs`=0, lines are timed from the `ext_h` edges, and V and F are taken from `ext_v`/`ext_f` on the line-start word. With `src_trs`=1, they are timed from timing words found in `din`.
- R3: A timing word is a word with bit 9 set that follows three words whose upper 8 bits are FF, 00, 00. The two low bits are ignored, so 10-bit and 8-bit preambles both count. In the timing word, bit 8 is F, bit 7 is V and bit 6 is H. H=1 marks end-of-active (line start) and H=0 marks start-of-active.
- R4: `meas_line_words` gives the words from one line start to the next. `meas_active_words` gives the words from the first word after the start-of-active sequence up to the word before the next end-of-active preamble. `meas_frame_lines` counts the lines per frame, and `meas_active_lines` counts the lines with V=0.
- R5: With `h_trs_mode`=0 (the default convention), `ext_h` is high over all of blanking, including both timing sequences. A rise marks the line start and a fall marks the first active word.
- R6: With `h_trs_mode`=1, `ext_h` falls on the first word of the start-of-active sequence, so the active length is the fall-to-rise span minus 4. The same bit also applies this 4-word correction in timing-word mode.
- R7: A frame boundary is a line start with V=1 whose previous line had V=0. `locked` rises one cycle after the line-start word of the boundary that closes the second of two consecutive, self-consistent frames with equal measurements. For a stream that begins on a boundary line, this is after word 2·frame+3 in timing-word mode and after word 2·frame in pin mode.
- R8: Clocks with `pix_en`=0 are ignored: no word is taken and no count advances.
- R9: While locked, `h_out` is high for the first (line − active) words of each regenerated line. The line is counted from the line-start word: the timing word of the end-of-active sequence, or the word where `ext_h` rises. `v_out` is high for the first (lines − active lines) lines after the boundary line. `f_out` gives F as sampled on the last boundary.
- R10: The regenerated outputs coast. Lines with missing timing leave `h_out`/`v_out` on their learned schedule, and isolated mismatches do not drop lock.
- R11: While locked, three consecutive line or frame measurements that differ from the stored geometry clear `locked` one cycle after the third. Learning then restarts and can lock onto the new geometry.
- R12: After reset, `locked`, the regenerated outputs and all measurement outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | One word is taken on each clock with this high |
| din | input | 10 | Parallel video word |
| ext_h | input | 1 | External horizontal timing |
| ext_v | input | 1 | External vertical timing |
| ext_f | input | 1 | External field timing |
| src_trs | input | 1 | 1: time from embedded words, 0: from pins |
| h_trs_mode | input | 1 | Horizontal convention select (see R5, R6) |
| mode_bypass | input | 1 | Must be 1 for operation |
| mode_asi | input | 1 | Must be 0 for operation |
| locked | output | 1 | Geometry learned and tracked |
| h_out | output | 1 | Regenerated horizontal blanking |
| v_out | output | 1 | Regenerated vertical blanking |
| f_out | output | 1 | Regenerated field bit |
| meas_line_words | output | HW | Learned words per line |
| meas_active_words | output | HW | Learned active words per line |
| meas_frame_lines | output | VW | Learned lines per frame |
| meas_active_lines | output | VW | Learned active lines per frame |

## Verification
A timing word or pin edge is acted on at the clock edge that takes it, so its effect shows one cycle later. Lock, loss of lock and the stored measurements change at the edge of the deciding line-start word. The bench samples a quarter period after each edge and checks the state right before and right after those exact words. The regenerated outputs are combinational from registered counters, so after word n is taken they describe word n+1. The bench computes that position arithmetically from the word index and the line-start offset (3 for timing words, 0 for pins), and checks every word over whole frames, including a three-line gap without timing. Mode gating is checked before any edge, and the cleared state is checked one edge later.

// File: rtl/vid_flywheel.sv
module vid_flywheel #(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int MISS_LIMIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [9:0]    din,
  input  logic          ext_h,
  input  logic          ext_v,
  input  logic          ext_f,
  input  logic          src_trs,
  input  logic          h_trs_mode,
  input  logic          mode_bypass,
  input  logic          mode_asi,
  output logic          locked,
  output logic          h_out,
  output logic          v_out,
  output logic          f_out,
  output logic [HW-1:0] meas_line_words,
  output logic [HW-1:0] meas_active_words,
  output logic [VW-1:0] meas_frame_lines,
  output logic [VW-1:0] meas_active_lines
);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam logic [HW-1:0] SEQ_LEN = HW'(4);

  logic [9:0] w1, w2, w3;
  logic h_d, v_q, f_cap;
  logic [HW-1:0] hpos, apos, f_tot, f_act, cand_tot, cand_act, sh_tot, sh_act, ghc;
  logic [VW-1:0] vcnt, acnt, cand_lines, cand_alines, sh_lines, sh_alines, gline;
  logic line_seen, apos_ok, fr_seen, f_have, f_ok, cand_ok, lock_q;
  logic [MW-1:0] miss;

  logic run, xyz, ls_evt, as_evt, cur_v, cur_f, boundary;
  logic m_ok, fin_ok, same_cand, line_bad, frame_bad;
  logic [HW-1:0] adj, m_tot, m_act, fin_tot, fin_act;

  assign run    = mode_bypass & ~mode_asi;
  assign xyz    = pix_en & din[9] & (w3[9:2] == 8'hFF) & (w2[9:2] == 8'h00) & (w1[9:2] == 8'h00);
  assign ls_evt = src_trs ? (xyz & din[6])  : (pix_en & ext_h & ~h_d);
  assign as_evt = src_trs ? (xyz & ~din[6]) : (pix_en & ~ext_h & h_d);
  assign cur_v  = src_trs ? din[7] : ext_v;
  assign cur_f  = src_trs ? din[8] : ext_f;
  assign adj    = (src_trs | h_trs_mode) ? SEQ_LEN : '0;
  assign boundary = ls_evt & cur_v & ~v_q;

  assign m_tot = hpos + 1'b1;
  assign m_act = hpos - apos - adj;
  assign m_ok  = line_seen & apos_ok;

  assign fin_tot = f_have ? f_tot : m_tot;
  assign fin_act = f_have ? f_act : m_act;
  assign fin_ok  = fr_seen & f_ok & m_ok & (vcnt != '0) & (fin_tot > HW'(1)) &
                   (!f_have || (m_tot == f_tot && m_act == f_act));
  assign same_cand = cand_ok && cand_tot == fin_tot && cand_act == fin_act &&
                     cand_lines == vcnt && cand_alines == acnt;

  assign line_bad  = (m_tot != sh_tot) || (m_act != sh_act);
  assign frame_bad = boundary && fr_seen && ((vcnt != sh_lines) || (acnt != sh_alines));

  assign locked = lock_q & run;
  assign h_out  = locked & (ghc < (sh_tot - sh_act));
  assign v_out  = locked & (gline < (sh_lines - sh_alines));
  assign f_out  = locked & f_cap;
  assign meas_line_words   = sh_tot;
  assign meas_active_words = sh_act;
  assign meas_frame_lines  = sh_lines;
  assign meas_active_lines = sh_alines;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      w1 <= '0; w2 <= '0; w3 <= '0; h_d <= 1'b0; v_q <= 1'b0; f_cap <= 1'b0;
      hpos <= '0; apos <= '0; line_seen <= 1'b0; apos_ok <= 1'b0;
      fr_seen <= 1'b0; vcnt <= '0; acnt <= '0;
      f_tot <= '0; f_act <= '0; f_have <= 1'b0; f_ok <= 1'b0;
      cand_ok <= 1'b0; cand_tot <= '0; cand_act <= '0; cand_lines <= '0; cand_alines <= '0;
      sh_tot <= '0; sh_act <= '0; sh_lines <= '0; sh_alines <= '0;
      lock_q <= 1'b0; miss <= '0; ghc <= '0; gline <= '0;
    end else if (pix_en) begin
      w3 <= w2; w2 <= w1; w1 <= din; h_d <= ext_h;

      if (ls_evt) begin
        hpos <= '0; line_seen <= 1'b1; apos_ok <= 1'b0;
      end else if (hpos != '1) begin
        hpos <= hpos + 1'b1;
      end
      if (as_evt) begin
        apos <= hpos; apos_ok <= 1'b1;
      end

      if (lock_q) begin
        if (ghc >= sh_tot - 1'b1) begin
          ghc <= '0;
          gline <= (gline >= sh_lines - 1'b1) ? '0 : gline + 1'b1;
        end else begin
          ghc <= ghc + 1'b1;
        end
      end

      if (ls_evt) begin
        v_q <= cur_v;
        if (boundary) begin
          fr_seen <= 1'b1; vcnt <= VW'(1); acnt <= VW'(!cur_v);
          f_have <= 1'b0; f_ok <= 1'b1; f_cap <= cur_f;
        end else begin
          if (vcnt != '1) vcnt <= vcnt + 1'b1;
          acnt <= acnt + VW'(!cur_v);
          if (!m_ok) f_ok <= 1'b0;
          else if (!f_have) begin
            f_have <= 1'b1; f_tot <= m_tot; f_act <= m_act;
          end else if (m_tot != f_tot || m_act != f_act) f_ok <= 1'b0;
        end

        if (!lock_q) begin
          if (boundary) begin
            if (fin_ok && same_cand) begin
              sh_tot <= fin_tot; sh_act <= fin_act; sh_lines <= vcnt; sh_alines <= acnt;
              lock_q <= 1'b1; miss <= '0; ghc <= HW'(1); gline <= '0;
            end else begin
              cand_ok <= fin_ok; cand_tot <= fin_tot; cand_act <= fin_act;
              cand_lines <= vcnt; cand_alines <= acnt;
            end
          end
        end else if (m_ok) begin
          if (line_bad || frame_bad) begin
            if (miss == MW'(MISS_LIMIT - 1)) begin
              lock_q <= 1'b0; cand_ok <= 1'b0; miss <= '0;
            end else begin
              miss <= miss + 1'b1;
            end
          end else begin
            miss <= '0;
          end
        end
      end
    end
  end

  assert_mode_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!lock_q && sh_tot == '0 && sh_lines == '0));

  assert_lock_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(boundary));

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && $past(lock_q)) |-> ($stable(sh_tot) && $stable(sh_act) && $stable(sh_lines)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pix_en) |=> ($stable(hpos) && $stable(vcnt) && $stable(ghc)));

  assert_gen_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (ghc < sh_tot && gline < sh_lines));

  assert_loss_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lock_q) && $past(run)) |-> ($past(miss) == MW'(MISS_LIMIT - 1)));
endmodule

// File: tb/vid_flywheel_tb_top.sv
module vid_flywheel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0, rst_n = 1'b0, pix_en = 1'b0;
  logic [9:0] din = '0;
  logic ext_h = 1'b0, ext_v = 1'b0, ext_f = 1'b0;
  logic src_trs = 1'b1, h_trs_mode = 1'b0, mode_bypass = 1'b1, mode_asi = 1'b0;
  logic locked, h_out, v_out, f_out;
  logic [11:0] mlw, maw;
  logic [10:0] mfl, mal;

  int nchk = 0, nfail = 0;
  int T = 20, SAVP = 8, L = 10, VB = 3;
  int wi = 0, ofs = 3;
  bit fbit = 0, eightbit = 0, hconv_hi = 0, gap = 0, trk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_flywheel dut_i (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .din(din),
    .ext_h(ext_h), .ext_v(ext_v), .ext_f(ext_f),
    .src_trs(src_trs), .h_trs_mode(h_trs_mode),
    .mode_bypass(mode_bypass), .mode_asi(mode_asi),
    .locked(locked), .h_out(h_out), .v_out(v_out), .f_out(f_out),
    .meas_line_words(mlw), .meas_active_words(maw),
    .meas_frame_lines(mfl), .meas_active_lines(mal)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (word %0d)", req, act, exp, wi);
    end
  endtask

  task automatic drive_word();
    int p, ln;
    logic v;
    logic [9:0] d;
    p = wi % T;
    ln = (wi / T) % L;
    v = (ln < VB);
    d = (p >= SAVP + 4) ? (10'h200 | 10'(p)) : 10'h040;
    if (p == 0 || p == SAVP) d = eightbit ? 10'h3FD : 10'h3FF;
    if (p == 1 || p == SAVP + 1) d = eightbit ? 10'h002 : 10'h000;
    if (p == 2 || p == SAVP + 2) d = eightbit ? 10'h001 : 10'h000;
    if (p == 3) d = {1'b1, fbit, v, 1'b1, 6'b0};
    if (p == SAVP + 3) d = {1'b1, fbit, v, 1'b0, 6'b0};
    if (gap) d = 10'h200;
    din = d;
    ext_h = hconv_hi ? (p < SAVP) : (p < SAVP + 4);
    ext_v = v;
    ext_f = fbit;
  endtask

  // R9 R10: after word m is taken the outputs describe word m+1
  task automatic track_check();
    int n, p, lc;
    n = wi + 1 - ofs;
    p = n % T;
    lc = (n / T) % L;
    chk(h_out == (p < SAVP + 4), "R9/R10 h_out", int'(h_out), int'(p < SAVP + 4));
    chk(v_out == (lc < VB), "R9/R10 v_out", int'(v_out), int'(lc < VB));
  endtask

  task automatic step(input bit en);
    @(negedge clk);
    pix_en = en;
    if (en) drive_word();
    else begin
      din = 10'h3FF;
      ext_h = ~ext_h;
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (en) begin
      if (trk) track_check();
      wi++;
    end
  endtask

  task automatic run_to(input int n);
    while (wi < n) step(1'b1);
  endtask

  task automatic restart();
    @(negedge clk);
    pix_en = 1'b0; ext_h = 1'b0; mode_asi = 1'b1;
    @(negedge clk);
    mode_asi = 1'b0;
    wi = 0; trk = 0; gap = 0;
  endtask

  task automatic check_meas(input string tag, input int tw, input int aw, input int fl, input int al);
    chk(mlw == 12'(tw), {tag, " line words"}, int'(mlw), tw);
    chk(maw == 12'(aw), {tag, " active words"}, int'(maw), aw);
    chk(mfl == 11'(fl), {tag, " frame lines"}, int'(mfl), fl);
    chk(mal == 11'(al), {tag, " active lines"}, int'(mal), al);
  endtask

  task automatic lock_edge(input string tag, input int w);
    run_to(w);
    chk(locked == 1'b0, {tag, " not yet locked"}, int'(locked), 0);
    step(1'b1);
    chk(locked == 1'b1, {tag, " locked"}, int'(locked), 1);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R7 watchdog expired actual=%0d expected=0", WD_CYCLES);
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #(CLK_PERIOD/4);
    // R12 reset state
    chk(locked == 0, "R12 locked", int'(locked), 0);
    chk(h_out == 0 && v_out == 0 && f_out == 0, "R12 hvf", int'({h_out, v_out, f_out}), 0);
    check_meas("R12", 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3 R4 R7: 10-bit timing words
    src_trs = 1; h_trs_mode = 0; fbit = 0; eightbit = 0; ofs = 3;
    wi = 0;
    lock_edge("R7 trs10", 403);
    check_meas("R3/R4 trs10", 20, 8, 10, 7);
    chk(f_out == 0, "R9 f_out", int'(f_out), 0);
    trk = 1;
    run_to(820);
    // R10: three lines without any timing words
    gap = 1; run_to(880); gap = 0;
    run_to(1300);
    chk(locked == 1, "R10 lock kept through gap", int'(locked), 1);

    // R1: mode gating
    @(negedge clk);
    pix_en = 0; trk = 0; mode_asi = 1; #1;
    chk(locked == 0, "R1 asi high locked", int'(locked), 0);
    chk(h_out == 0 && v_out == 0, "R1 asi high outputs", int'({h_out, v_out}), 0);
    @(posedge clk); #(CLK_PERIOD/4);
    check_meas("R1 cleared", 0, 0, 0, 0);
    @(negedge clk); mode_asi = 0; mode_bypass = 0; #1;
    chk(locked == 0, "R1 bypass low locked", int'(locked), 0);
    @(negedge clk); mode_bypass = 1;
    @(posedge clk); #(CLK_PERIOD/4);
    chk(locked == 0, "R1 relearn needed", int'(locked), 0);

    // R3 R9: 8-bit preambles, F=1
    restart();
    eightbit = 1; fbit = 1;
    lock_edge("R3 trs8", 403);
    check_meas("R3 trs8", 20, 8, 10, 7);
    chk(f_out == 1, "R9 f_out", int'(f_out), 1);
    eightbit = 0; fbit = 0;

    // R2 R5: pins, default convention
    restart();
    src_trs = 0; h_trs_mode = 0; hconv_hi = 0; ofs = 0;
    lock_edge("R2/R5 pins", 400);
    check_meas("R5 pins", 20, 8, 10, 7);
    trk = 1; run_to(800); trk = 0;

    // R6: pins, blanking-by-timing-word convention
    restart();
    h_trs_mode = 1; hconv_hi = 1;
    lock_edge("R6 pins", 400);
    check_meas("R6 pins", 20, 8, 10, 7);

    // R6: convention bit set but H driven the default way: active shrinks by 4
    restart();
    h_trs_mode = 1; hconv_hi = 0;
    run_to(401);
    check_meas("R6 mismatch", 20, 4, 10, 7);
    h_trs_mode = 0;

    // R8: idle clocks interleaved
    restart();
    src_trs = 1; ofs = 3;
    while (wi < 403) begin step(1'b1); step(1'b0); end
    chk(locked == 0, "R8 idle not yet locked", int'(locked), 0);
    step(1'b1);
    chk(locked == 1, "R8 idle locked", int'(locked), 1);
    repeat (3) step(1'b0);
    check_meas("R8 idle", 20, 8, 10, 7);

    // R11: loss after three bad lines, then relearn
    restart();
    run_to(600);
    chk(locked == 1, "R11 locked before change", int'(locked), 1);
    T = 24; wi = 0;
    run_to(75);
    chk(locked == 1, "R11 two mismatches", int'(locked), 1);
    step(1'b1);
    chk(locked == 0, "R11 third mismatch", int'(locked), 0);
    lock_edge("R11 relock", 483);
    check_meas("R11 relock", 24, 12, 10, 7);

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule